// File: doc/BRIEF.md
# Quasi-Bidirectional Port with Alternate Functions

This block is an eight-bit general-purpose port in which every pin is driven only by a pull-down. An external or weak pull-up is assumed on each pin. Each bit has an output latch. A latch bit of 0 turns the pull-down on, so the pin reads low. A latch bit of 1 releases the pin. The pin then reads high unless something outside pulls it low, so a released bit works as an input. The pin level sensed from outside comes back on `pin_in` and is used both for CPU reads and for the alternate input functions.

The CPU side takes one request at a time while `ready` is high. It can:
- write the whole latch byte;
- set, clear or toggle one addressed latch bit;
- read back either the sensed pin levels or the latch contents.

Single-bit operations are read-modify-write cycles. They start from the latch, not from the pins, so a bit held low from outside is not rewritten as 0.

Selected bits also carry alternate functions:
- bit 0 is the serial receive input and bit 1 the serial transmit output;
- bits 2 and 3 are two active-low interrupt inputs;
- bits 4 and 5 are two counter inputs;
- bits 6 and 7 are the external write and read strobes.

An alternate output is ANDed with its latch bit, so the latch must hold 1 for the alternate signal to control the pin. Alternate inputs always see the sensed pin level.

A small sequencer runs the CPU access. Its states are `ST_IDLE`, `ST_FETCH`, `ST_COMMIT` and `ST_RESPOND`. The transitions are:
- IDLE→COMMIT on a byte write;
- IDLE→FETCH on a bit operation;
- FETCH→COMMIT always;
- IDLE→RESPOND on a read;
- COMMIT→IDLE and RESPOND→IDLE always;
- IDLE→IDLE with no request or with an unused code.

Top module: `qbp_port`

## Requirements
- R1: After synchronous reset (`rst` high) the latch holds all ones. `ready` is 1, `rd_valid` is 0, and with no alternate selected every `pd_en` bit is 0.
- R2: Op code 1 (byte write), accepted on the edge where `req` and `ready` are both high, loads `wdata` into the latch two clock edges later (state path IDLE→COMMIT→IDLE).
- R3: Any bit whose latch holds 0 has its `pd_en` bit at 1, whatever the alternate settings.
- R4: Any bit whose latch holds 1 and whose `alt_sel` bit is 0 has its `pd_en` bit at 0.
- R5: Op codes 2 (set), 3 (clear) and 4 (toggle) change only latch bit `bit_idx`, and the result is taken from the latch contents. The new latch is in place three edges after acceptance (IDLE→FETCH→COMMIT→IDLE). Other bits are unchanged even when their pins are held low from outside.
- R6: Op code 5 (read pins) returns the value `pin_in` had on the accept edge. The value appears on `rdata` while `rd_valid` is high, for exactly the one cycle after acceptance.
- R7: Op code 6 (read latch) returns the latch contents on `rdata` with the same one-cycle `rd_valid` timing.
- R8: When `alt_sel` bit 1, 6 or 7 is 1, that bit's `pd_en` is the inverse of (latch bit AND alternate output). The alternate outputs are `txd_alt` (bit 1), `wr_n_alt` (bit 6) and `rd_n_alt` (bit 7).
- R9: Bits 0, 2, 3, 4 and 5 have no alternate output, so their `alt_sel` bits have no effect on `pd_en`.
- R10: The alternate inputs follow the sensed pins whatever `alt_sel` holds: `rxd_in` = `pin_in[0]`, `int0_n_in` = `pin_in[2]`, `int1_n_in` = `pin_in[3]`, `cnt0_in` = `pin_in[4]` and `cnt1_in` = `pin_in[5]`.
- R11: The following are ignored, leaving the latch unchanged and raising no `rd_valid`:
  - a request made while `ready` is 0;
  - op code 0;
  - op code 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, taken when `ready` is 1 |
| op | input | 3 | Operation code (see R2, R5, R6, R7, R11) |
| bit_idx | input | 3 | Bit addressed by set, clear and toggle |
| wdata | input | 8 | Byte for a byte write |
| ready | output | 1 | Sequencer idle, request accepted |
| rd_valid | output | 1 | Read data valid |
| rdata | output | 8 | Read result |
| pin_in | input | 8 | Sensed pin levels |
| pd_en | output | 8 | Per-bit pull-down enable (1 pulls the pin low) |
| alt_sel | input | 8 | Per-bit alternate-function select |
| txd_alt | input | 1 | Serial transmit output for bit 1 |
| wr_n_alt | input | 1 | Write strobe for bit 6 |
| rd_n_alt | input | 1 | Read strobe for bit 7 |
| rxd_in | output | 1 | Serial receive input from bit 0 |
| int0_n_in | output | 1 | Interrupt input from bit 2 |
| int1_n_in | output | 1 | Interrupt input from bit 3 |
| cnt0_in | output | 1 | Counter input from bit 4 |
| cnt1_in | output | 1 | Counter input from bit 5 |

## Verification
The hardest case to reach from the ports is a single-bit operation on a port whose other pins are held low from outside while their latch bits are 1. A read-modify-write that worked from the pins would corrupt exactly those bits. The bench models the outside world as a per-bit external pull-down that it combines with `pd_en` to form `pin_in`. The random stimulus draws that external mask, the alternate selects and the strobe levels afresh before every operation. Directed cases then hold pins low during set and clear operations and issue a second request while the sequencer is busy.

// File: rtl/qbp_pkg.sv
package qbp_pkg;

    // CPU operation codes
    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_WRITE    = 3'd1,
        OP_SET      = 3'd2,
        OP_CLR      = 3'd3,
        OP_TOGGLE   = 3'd4,
        OP_RD_PIN   = 3'd5,
        OP_RD_LATCH = 3'd6,
        OP_RSVD     = 3'd7
    } op_e;

    // Access sequencer states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_COMMIT  = 2'd2,
        ST_RESPOND = 2'd3
    } state_e;

    // Alternate function bit positions (decoded by neighbouring blocks)
    localparam int ALT_RXD  = 0;
    localparam int ALT_TXD  = 1;
    localparam int ALT_INT0 = 2;
    localparam int ALT_INT1 = 3;
    localparam int ALT_CNT0 = 4;
    localparam int ALT_CNT1 = 5;
    localparam int ALT_WR   = 6;
    localparam int ALT_RD   = 7;

    // Bits whose alternate function drives the pin
    localparam logic [7:0] ALT_OUT_MASK = 8'b1100_0010;

endpackage

// File: rtl/qbp_latch.sv
module qbp_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Resets to all ones: every pin released and usable as input
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '1;
        end else if (we) begin
            q <= d;
        end
    end
endmodule

// File: rtl/qbp_pinmux.sv
module qbp_pinmux #(
    parameter int             WIDTH    = 8,
    parameter logic [WIDTH-1:0] ALT_MASK = '0
) (
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] alt_sel,
    input  logic [WIDTH-1:0] alt_val,
    output logic [WIDTH-1:0] pd_en
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic sel_eff;
        logic drive;
        // Only bits that own an alternate output can be taken over
        assign sel_eff  = alt_sel[i] & ALT_MASK[i];
        assign drive    = sel_eff ? alt_val[i] : 1'b1;
        // Pull-down on unless both latch and alternate say "release"
        assign pd_en[i] = ~(latch_q[i] & drive);
    end
endmodule

// File: rtl/qbp_ctrl.sv
module qbp_ctrl
    import qbp_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [2:0]       op,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] pin_lvl,
    output logic             ready,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rdata,
    output logic             latch_we,
    output logic [WIDTH-1:0] latch_d,
    output logic [1:0]       state_o,
    output logic [2:0]       op_o
);
    state_e            state_q, state_d;
    op_e               op_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WIDTH-1:0]  work_q;
    logic [WIDTH-1:0]  rdata_q;

    function automatic logic [WIDTH-1:0] bit_apply(
        input logic [WIDTH-1:0] base,
        input op_e              kind,
        input logic [IDX_W-1:0] idx
    );
        logic [WIDTH-1:0] mask;
        mask = '0;
        mask[idx] = 1'b1;
        unique case (kind)
            OP_SET:    bit_apply = base | mask;
            OP_CLR:    bit_apply = base & ~mask;
            OP_TOGGLE: bit_apply = base ^ mask;
            default:   bit_apply = base;
        endcase
    endfunction

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    unique case (op_e'(op))
                        OP_WRITE:                   state_d = ST_COMMIT;
                        OP_SET, OP_CLR, OP_TOGGLE:  state_d = ST_FETCH;
                        OP_RD_PIN, OP_RD_LATCH:     state_d = ST_RESPOND;
                        default:                    state_d = ST_IDLE;
                    endcase
                end
            end
            ST_FETCH:   state_d = ST_COMMIT;
            ST_COMMIT:  state_d = ST_IDLE;
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers driven by the state
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_NOP;
            idx_q   <= '0;
            work_q  <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        op_q  <= op_e'(op);
                        idx_q <= bit_idx;
                        if (op_e'(op) == OP_WRITE)     work_q  <= wdata;
                        if (op_e'(op) == OP_RD_PIN)    rdata_q <= pin_lvl;
                        if (op_e'(op) == OP_RD_LATCH)  rdata_q <= latch_q;
                    end
                end
                ST_FETCH:   work_q <= bit_apply(latch_q, op_q, idx_q);
                default: ;
            endcase
        end
    end

    // Outputs from state
    always_comb begin
        ready    = (state_q == ST_IDLE);
        rd_valid = (state_q == ST_RESPOND);
        latch_we = (state_q == ST_COMMIT);
        latch_d  = work_q;
        rdata    = rdata_q;
        state_o  = state_q;
        op_o     = op_q;
    end
endmodule

// File: rtl/qbp_port.sv
module qbp_port
    import qbp_pkg::*;
#(
    parameter int WIDTH = 8   // at least 8: alternate positions are fixed
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [2:0]       op,
    input  logic [$clog2(WIDTH)-1:0] bit_idx,
    input  logic [WIDTH-1:0] wdata,
    output logic             ready,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pd_en,
    input  logic [WIDTH-1:0] alt_sel,
    input  logic             txd_alt,
    input  logic             wr_n_alt,
    input  logic             rd_n_alt,
    output logic             rxd_in,
    output logic             int0_n_in,
    output logic             int1_n_in,
    output logic             cnt0_in,
    output logic             cnt1_in
);
    localparam int IDX_W = $clog2(WIDTH);
    localparam logic [WIDTH-1:0] OUT_MASK = WIDTH'(ALT_OUT_MASK);

    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] latch_d;
    logic             latch_we;
    logic [WIDTH-1:0] alt_val;
    logic [1:0]       state_w;
    logic [2:0]       op_w;

    qbp_ctrl #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .op       (op),
        .bit_idx  (bit_idx),
        .wdata    (wdata),
        .latch_q  (latch_q),
        .pin_lvl  (pin_in),
        .ready    (ready),
        .rd_valid (rd_valid),
        .rdata    (rdata),
        .latch_we (latch_we),
        .latch_d  (latch_d),
        .state_o  (state_w),
        .op_o     (op_w)
    );

    qbp_latch #(.WIDTH(WIDTH)) u_latch (
        .clk (clk),
        .rst (rst),
        .we  (latch_we),
        .d   (latch_d),
        .q   (latch_q)
    );

    // Alternate output values; unused positions read as "release"
    always_comb begin
        alt_val          = '1;
        alt_val[ALT_TXD] = txd_alt;
        alt_val[ALT_WR]  = wr_n_alt;
        alt_val[ALT_RD]  = rd_n_alt;
    end

    qbp_pinmux #(.WIDTH(WIDTH), .ALT_MASK(OUT_MASK)) u_pinmux (
        .latch_q (latch_q),
        .alt_sel (alt_sel),
        .alt_val (alt_val),
        .pd_en   (pd_en)
    );

    // Alternate inputs always see the sensed pin
    assign rxd_in    = pin_in[ALT_RXD];
    assign int0_n_in = pin_in[ALT_INT0];
    assign int1_n_in = pin_in[ALT_INT1];
    assign cnt0_in   = pin_in[ALT_CNT0];
    assign cnt1_in   = pin_in[ALT_CNT1];
endmodule

// File: rtl/qbp_port_chk.sv
module qbp_port_chk
    import qbp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ready,
    input logic             rd_valid,
    input logic [WIDTH-1:0] latch_q,
    input logic [WIDTH-1:0] pd_en,
    input logic [WIDTH-1:0] alt_sel,
    input logic [1:0]       state_q,
    input logic [2:0]       op_q
);
    p_reset_ones_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (latch_q == '1) && ready && !rd_valid);

    p_low_pulls_r3: assert property (@(posedge clk) disable iff (rst)
        ((~latch_q) & (~pd_en)) == '0);

    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        (latch_q & ~alt_sel & pd_en) == '0);

    p_single_bit_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_COMMIT && $past(op_q) != OP_WRITE)
        |-> $countones(latch_q ^ $past(latch_q)) <= 1);

    p_rd_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> (!rd_valid && ready));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        ready |=> $stable(latch_q));
endmodule

bind qbp_port qbp_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ready    (ready),
    .rd_valid (rd_valid),
    .latch_q  (latch_q),
    .pd_en    (pd_en),
    .alt_sel  (alt_sel),
    .state_q  (state_w),
    .op_q     (op_w)
);

// File: tb/tb_qbp_port.sv
module tb_qbp_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic [2:0] op = 3'd0;
    logic [2:0] bit_idx = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic       ready, rd_valid;
    logic [7:0] rdata;
    logic [7:0] pin_in;
    logic [7:0] pd_en;
    logic [7:0] alt_sel = 8'h00;
    logic       txd_alt = 1'b1, wr_n_alt = 1'b1, rd_n_alt = 1'b1;
    logic       rxd_in, int0_n_in, int1_n_in, cnt0_in, cnt1_in;
    logic [7:0] ext_low = 8'h00;   // outside world pulling pins low

    int checks = 0;
    int failures = 0;
    logic [7:0] model = 8'hFF;

    always #5 clk = ~clk;

    assign pin_in = ~pd_en & ~ext_low;

    qbp_port dut (
        .clk(clk), .rst(rst), .req(req), .op(op), .bit_idx(bit_idx),
        .wdata(wdata), .ready(ready), .rd_valid(rd_valid), .rdata(rdata),
        .pin_in(pin_in), .pd_en(pd_en), .alt_sel(alt_sel),
        .txd_alt(txd_alt), .wr_n_alt(wr_n_alt), .rd_n_alt(rd_n_alt),
        .rxd_in(rxd_in), .int0_n_in(int0_n_in), .int1_n_in(int1_n_in),
        .cnt0_in(cnt0_in), .cnt1_in(cnt1_in)
    );

    function automatic logic [7:0] exp_pd(input logic [7:0] lat);
        logic [7:0] drv;
        drv = 8'hFF;
        if (alt_sel[1]) drv[1] = txd_alt;
        if (alt_sel[6]) drv[6] = wr_n_alt;
        if (alt_sel[7]) drv[7] = rd_n_alt;
        return ~(lat & drv);
    endfunction

    function automatic logic [7:0] exp_latch(input logic [7:0] lat,
                                             input logic [2:0] o,
                                             input logic [2:0] idx,
                                             input logic [7:0] d);
        logic [7:0] m;
        m = 8'h01 << idx;
        case (o)
            3'd1: return d;
            3'd2: return lat | m;
            3'd3: return lat & ~m;
            3'd4: return lat ^ m;
            default: return lat;
        endcase
    endfunction

    task automatic check(input bit ok, input string req_tag,
                         input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req_tag, act, expv);
        end
    endtask

    // Issue one request; return read data and whether rd_valid rose
    task automatic issue(input logic [2:0] o, input logic [2:0] idx,
                         input logic [7:0] d, output logic [7:0] rd,
                         output bit got);
        @(negedge clk);
        req = 1'b1; op = o; bit_idx = idx; wdata = d;
        @(negedge clk);
        req = 1'b0;
        got = rd_valid;
        rd = rdata;
        while (!ready) @(negedge clk);
    endtask

    task automatic read_latch_check(input string tag);
        logic [7:0] rd;
        bit got;
        issue(3'd6, 3'd0, 8'h00, rd, got);
        check(got && rd == model, tag, rd, model);
    endtask

    task automatic check_alt_in(input string tag);
        logic [7:0] a, e;
        a = {3'b0, cnt1_in, cnt0_in, int1_n_in, int0_n_in, rxd_in};
        e = {3'b0, pin_in[5], pin_in[4], pin_in[3], pin_in[2], pin_in[0]};
        check(a == e, tag, a, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=00 expected=01");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        bit got;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(pd_en == 8'h00, "R1 pd_en after reset", pd_en, 8'h00);
        check(ready && !rd_valid, "R1 ready after reset", {6'b0, ready, rd_valid}, 8'h02);
        read_latch_check("R1/R7 latch after reset");

        // R2 byte write, R3/R4 pull-down rule
        issue(3'd1, 3'd0, 8'hA5, rd, got);
        model = 8'hA5;
        check(pd_en == 8'h5A, "R2/R3/R4 pd after write", pd_en, 8'h5A);
        read_latch_check("R2 latch after write");

        // R6 read pins with external low on released bits
        ext_low = 8'h21;
        issue(3'd5, 3'd0, 8'h00, rd, got);
        check(got && rd == 8'h84, "R6 read pins", rd, 8'h84);

        // R5 bit ops work from latch while pins held low
        issue(3'd2, 3'd6, 8'h00, rd, got);
        model = 8'hE5;
        read_latch_check("R5 set bit6 with pins 0,5 low");
        issue(3'd3, 3'd2, 8'h00, rd, got);
        model = 8'hE1;
        read_latch_check("R5 clear bit2 with pins low");
        issue(3'd4, 3'd7, 8'h00, rd, got);
        model = 8'h61;
        read_latch_check("R5 toggle bit7");
        ext_low = 8'h00;

        // R11 busy request ignored
        @(negedge clk);
        req = 1'b1; op = 3'd1; wdata = 8'h3C;
        @(negedge clk);
        op = 3'd1; wdata = 8'hC3;      // held while COMMIT: must be ignored
        @(negedge clk);
        req = 1'b0;
        while (!ready) @(negedge clk);
        model = 8'h3C;
        read_latch_check("R11 request while busy");

        // R11 unused codes
        issue(3'd0, 3'd0, 8'h00, rd, got);
        check(!got, "R11 op0 no rd_valid", {7'b0, got}, 8'h00);
        issue(3'd7, 3'd0, 8'h00, rd, got);
        check(!got, "R11 op7 no rd_valid", {7'b0, got}, 8'h00);
        read_latch_check("R11 latch after unused codes");

        // R8 alternate outputs
        issue(3'd1, 3'd0, 8'hFF, rd, got);
        model = 8'hFF;
        alt_sel = 8'hC2; txd_alt = 1'b0; wr_n_alt = 1'b1; rd_n_alt = 1'b0;
        @(negedge clk);
        check(pd_en == 8'h82, "R8 alt outputs drive", pd_en, 8'h82);
        txd_alt = 1'b1; rd_n_alt = 1'b1; wr_n_alt = 1'b0;
        @(negedge clk);
        check(pd_en == 8'h40, "R8 wr strobe low", pd_en, 8'h40);
        issue(3'd3, 3'd1, 8'h00, rd, got);
        model = 8'hFD;
        check(pd_en == 8'h42, "R8 latch 0 overrides txd high", pd_en, 8'h42);

        // R9 selects without output have no effect
        alt_sel = 8'h3D; wr_n_alt = 1'b1;
        @(negedge clk);
        check(pd_en == 8'h02, "R9 input-only selects", pd_en, 8'h02);

        // R10 alternate inputs follow pins under either select
        ext_low = 8'h14;
        @(negedge clk);
        check_alt_in("R10 inputs with select");
        alt_sel = 8'h00;
        @(negedge clk);
        check_alt_in("R10 inputs without select");
        ext_low = 8'h00;

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [2:0] o, idx;
            logic [7:0] d, pexp;
            ext_low  = 8'($urandom) & 8'($urandom);
            alt_sel  = 8'($urandom);
            txd_alt  = 1'($urandom);
            wr_n_alt = 1'($urandom);
            rd_n_alt = 1'($urandom);
            o   = 3'($urandom);
            idx = 3'($urandom);
            d   = 8'($urandom);
            pexp = ~exp_pd(model) & ~ext_low;
            issue(o, idx, d, rd, got);
            case (o)
                3'd5: check(got && rd == pexp, "R6 random read pins", rd, pexp);
                3'd6: check(got && rd == model, "R7 random read latch", rd, model);
                3'd0, 3'd7: check(!got, "R11 random unused op", {7'b0, got}, 8'h00);
                default: begin
                    model = exp_latch(model, o, idx, d);
                    check(!got, "R2/R5 no rd_valid on write", {7'b0, got}, 8'h00);
                end
            endcase
            check(pd_en == exp_pd(model), "R3/R4/R8/R9 random pd_en", pd_en, exp_pd(model));
            check_alt_in("R10 random alternate inputs");
        end
        read_latch_check("R5 final latch");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule